// File: doc/BRIEF.md
# Descriptor-Chain Receive DMA Engine

This block takes a stream of 32-bit words and writes them into memory. It finds where to put each word by walking a linked list of descriptors that sit in the same memory. Software first places a chain of three-word descriptors in memory. It then programs the address of the first descriptor, a frame length counted in 32-bit words, and the interrupt enables. A start command sets the engine going. Words arrive on a valid/ready port and go into an internal FIFO. The engine drains the FIFO into the buffer of the current descriptor. When the engine finishes with a descriptor, it writes the descriptor's first word back with the owner bit cleared and the stored byte count filled in. It then follows the next pointer.

Three sticky interrupt sources are kept: buffer complete, frame complete and ownership error. Each is gated by its own enable. The frame length is a word count and is independent of the per-descriptor byte sizes. Programming a byte count there delays or suppresses the frame-complete interrupt. The memory port is a single-cycle master: a write takes effect at the clock edge where it is requested, and read data appears on `mem_rdata` in the cycle after the request.

Top module: `dmarx_chain_dma`

## Requirements
- R1: After reset, `irq_done`, `irq_eof`, `irq_err` and `mem_req` are low and `in_ready` is high.
- R2: A descriptor is three words: control word at the descriptor address, buffer pointer at +4, next pointer at +8. The control word holds owner at bit 31, an end flag at bit 30, length at bits 23:12 and size at bits 11:0. If the fetched control word has owner = 0, the engine raises the error source (bit 2), writes nothing, and goes idle.
- R3: Input words are stored in arrival order at consecutive word addresses, starting at the descriptor's buffer pointer.
- R4: On write-back, the control word is rewritten with bit 31 cleared and bits 23:12 set to the number of bytes stored. All other bits keep their values. Setting only the owner bit again makes the descriptor reusable.
- R5: The done source (bit 0) is raised when a descriptor's buffer holds size/4 words (at most 1023).
- R6: After write-back, the engine follows a non-zero next pointer. A next pointer of zero ends the transfer.
- R7: The frame-complete source (bit 1) is raised when the total number of stored words since start equals the programmed word count (0 disables it). The current descriptor is then written back with its partial length, and the engine stops.
- R8: Register map on `reg_addr`: 0 control (bit 0 start, bit 1 soft reset), 1 first descriptor address (20 bits), 2 frame word count, 3 enables, 4 raw status (read), 5 clear (write 1). Status bits are sticky until cleared. Each output is raw AND enable.
- R9: The input FIFO holds FIFO_DEPTH words. When it is full, `in_ready` is low.
- R10: While the soft-reset bit is 1, the FIFO is emptied, the engine is held idle and `in_ready` is low. Clearing the bit restores normal operation with an empty FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | FIFO can accept a word |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_done | output | 1 | Buffer-complete interrupt |
| irq_eof | output | 1 | Frame-complete interrupt |
| irq_err | output | 1 | Ownership-error interrupt |

## Verification
The bench builds the engine with FIFO_DEPTH = 8 and leaves the other parameters at their defaults. The small depth lets a short burst fill the FIFO, so back-pressure and the soft-reset flush can be seen within a few cycles. Descriptor sizes of a few words keep each chain short. With these sizes the frame count can end a transfer in the middle of the second descriptor, and the clamp at 1023 words stays outside the tested range.

// File: rtl/dmarx_pkg.sv
package dmarx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_D0, ST_D1, ST_D2, ST_D3, ST_FILL, ST_WB
   } dma_st_e;

   // control word layout
   localparam int OWN_BIT  = 31;
   localparam int LEN_LSB  = 12;
   localparam int LEN_W    = 12;
   localparam int SIZE_W   = 12;

   // interrupt source indices
   localparam int IRQ_DONE = 0;
   localparam int IRQ_EOF  = 1;
   localparam int IRQ_ERR  = 2;
   localparam int IRQ_N    = 3;

   // register indices
   localparam logic [2:0] RA_CTRL = 3'd0;
   localparam logic [2:0] RA_HEAD = 3'd1;
   localparam logic [2:0] RA_EOFN = 3'd2;
   localparam logic [2:0] RA_ENA  = 3'd3;
   localparam logic [2:0] RA_RAW  = 3'd4;
   localparam logic [2:0] RA_CLR  = 3'd5;
endpackage

// File: rtl/dmarx_fifo.sv
module dmarx_fifo #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             full,
   output logic             empty
);
   localparam int PW = $clog2(DEPTH);

   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("dmarx_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [WIDTH-1:0] store [DEPTH];
   logic [PW:0]      wp_q, rp_q;
   logic [PW:0]      level;

   assign level = wp_q - rp_q;
   assign full  = (level == (PW+1)'(DEPTH));
   assign empty = (wp_q == rp_q);
   assign dout  = store[rp_q[PW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q <= '0;
         rp_q <= '0;
      end else if (flush) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (push) wp_q <= wp_q + 1'b1;
         if (pop)  rp_q <= rp_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) store[wp_q[PW-1:0]] <= din;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full); // R9
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R3
endmodule

// File: rtl/dmarx_irq.sv
module dmarx_irq #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   input  logic [N-1:0] ena,
   output logic [N-1:0] raw,
   output logic [N-1:0] out
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw <= '0;
      else        raw <= (raw & ~clr) | set;
   end

   assign out = raw & ena;

   AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(raw) & ~$past(clr)) & ~raw) == '0)); // R8
endmodule

// File: rtl/dmarx_chain_dma.sv
module dmarx_chain_dma
   import dmarx_pkg::*;
#(
   parameter int ADDR_W         = 20,
   parameter int DATA_W         = 32,
   parameter int FIFO_DEPTH     = 64,
   parameter int EOFN_W         = 32,
   parameter int MAX_DESC_WORDS = 1023
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq_done,
   output logic              irq_eof,
   output logic              irq_err
);
   localparam int CNT_W = $clog2(MAX_DESC_WORDS + 1);
   localparam int SW_W  = SIZE_W - 2;

   if (DATA_W != 32) begin : g_bad_data
      $error("dmarx_chain_dma: DATA_W must be 32");
   end
   if ((ADDR_W < 12) || (ADDR_W > 32)) begin : g_bad_addr
      $error("dmarx_chain_dma: ADDR_W out of range");
   end
   if ((CNT_W + 2 > LEN_W) || (EOFN_W > 32)) begin : g_bad_cnt
      $error("dmarx_chain_dma: counter widths exceed descriptor fields");
   end

   // ---------------- registers ----------------
   logic [ADDR_W-1:0] head_q;
   logic [EOFN_W-1:0] eofn_q;
   logic [IRQ_N-1:0]  ena_q, raw, clr_v, set_v, irq_v;
   logic              soft_rst_q, start_p;

   assign start_p = reg_we && (reg_addr == RA_CTRL) && reg_wdata[0] && !reg_wdata[1];
   assign clr_v   = (reg_we && (reg_addr == RA_CLR)) ? reg_wdata[IRQ_N-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q     <= '0;
         eofn_q     <= '0;
         ena_q      <= '0;
         soft_rst_q <= 1'b0;
      end else if (reg_we) begin
         case (reg_addr)
            RA_CTRL: soft_rst_q <= reg_wdata[1];
            RA_HEAD: head_q     <= reg_wdata[ADDR_W-1:0];
            RA_EOFN: eofn_q     <= reg_wdata[EOFN_W-1:0];
            RA_ENA:  ena_q      <= reg_wdata[IRQ_N-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_CTRL: reg_rdata[1]          = soft_rst_q;
         RA_HEAD: reg_rdata             = 32'(head_q);
         RA_EOFN: reg_rdata             = 32'(eofn_q);
         RA_ENA:  reg_rdata[IRQ_N-1:0]  = ena_q;
         RA_RAW:  reg_rdata[IRQ_N-1:0]  = raw;
         default: reg_rdata             = '0;
      endcase
   end

   // ---------------- input FIFO ----------------
   logic              f_full, f_empty, f_push, f_pop;
   logic [DATA_W-1:0] f_dout;

   assign in_ready = !f_full && !soft_rst_q;
   assign f_push   = in_valid && in_ready;

   dmarx_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(soft_rst_q),
      .push(f_push), .din(in_data), .pop(f_pop),
      .dout(f_dout), .full(f_full), .empty(f_empty)
   );

   // ---------------- descriptor walker ----------------
   dma_st_e           st;
   logic [ADDR_W-1:0] cur_q, buf_q, nxt_q;
   logic [DATA_W-1:0] w0_q, wb_word;
   logic [CNT_W-1:0]  fill_q, need;
   logic [EOFN_W-1:0] total_q;
   logic              eof_hit_q, fill_go, eof_now, full_now;
   logic [SW_W-1:0]   size_words;

   assign size_words = w0_q[SIZE_W-1:2];
   assign need       = (int'(size_words) > MAX_DESC_WORDS) ? CNT_W'(MAX_DESC_WORDS)
                                                          : CNT_W'(size_words);
   assign fill_go    = (st == ST_FILL) && (fill_q != need) && !f_empty;
   assign f_pop      = fill_go;
   assign eof_now    = fill_go && (eofn_q != '0) && ((total_q + EOFN_W'(1)) == eofn_q);
   assign full_now   = fill_go && ((fill_q + CNT_W'(1)) == need);

   always_comb begin
      wb_word                       = w0_q;
      wb_word[OWN_BIT]              = 1'b0;
      wb_word[LEN_LSB +: LEN_W]     = LEN_W'({fill_q, 2'b00});
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      case (st)
         ST_D0: begin mem_req = 1'b1; mem_addr = cur_q; end
         ST_D1: begin mem_req = 1'b1; mem_addr = cur_q + ADDR_W'(4); end
         ST_D2: begin mem_req = 1'b1; mem_addr = cur_q + ADDR_W'(8); end
         ST_FILL: if (fill_go) begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = buf_q + ADDR_W'({fill_q, 2'b00});
            mem_wdata = f_dout;
         end
         ST_WB: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cur_q;
            mem_wdata = wb_word;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cur_q     <= '0;
         buf_q     <= '0;
         nxt_q     <= '0;
         w0_q      <= '0;
         fill_q    <= '0;
         total_q   <= '0;
         eof_hit_q <= 1'b0;
      end else if (soft_rst_q) begin
         st <= ST_IDLE;
      end else begin
         case (st)
            ST_IDLE: if (start_p) begin
               cur_q     <= head_q;
               total_q   <= '0;
               eof_hit_q <= 1'b0;
               st        <= ST_D0;
            end
            ST_D0: st <= ST_D1;
            ST_D1: begin
               w0_q <= mem_rdata;
               st   <= mem_rdata[OWN_BIT] ? ST_D2 : ST_IDLE;
            end
            ST_D2: begin
               buf_q <= mem_rdata[ADDR_W-1:0];
               st    <= ST_D3;
            end
            ST_D3: begin
               nxt_q  <= mem_rdata[ADDR_W-1:0];
               fill_q <= '0;
               st     <= ST_FILL;
            end
            ST_FILL: begin
               if (fill_q == need) st <= ST_WB;
               else if (fill_go) begin
                  fill_q  <= fill_q + CNT_W'(1);
                  total_q <= total_q + EOFN_W'(1);
                  if (eof_now) eof_hit_q <= 1'b1;
                  if (eof_now || full_now) st <= ST_WB;
               end
            end
            ST_WB: begin
               if (eof_hit_q || (nxt_q == '0)) st <= ST_IDLE;
               else begin
                  cur_q <= nxt_q;
                  st    <= ST_D0;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // ---------------- interrupts ----------------
   always_comb begin
      set_v           = '0;
      set_v[IRQ_DONE] = (st == ST_WB) && (fill_q == need);
      set_v[IRQ_EOF]  = eof_now;
      set_v[IRQ_ERR]  = (st == ST_D1) && !mem_rdata[OWN_BIT];
   end

   dmarx_irq #(.N(IRQ_N)) u_irq (
      .clk(clk), .rst_n(rst_n), .set(set_v), .clr(clr_v),
      .ena(ena_q), .raw(raw), .out(irq_v)
   );

   assign irq_done = irq_v[IRQ_DONE];
   assign irq_eof  = irq_v[IRQ_EOF];
   assign irq_err  = irq_v[IRQ_ERR];

   AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_D1) && !mem_rdata[OWN_BIT]) |=> !mem_we); // R2
   AST_EOF_STOPS: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_q)
      eof_now |=> (st == ST_WB) ##1 (st == ST_IDLE)); // R7
endmodule

// File: tb/dmarx_chain_dma_test.sv
module dmarx_chain_dma_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_ready;
   logic        mem_req, mem_we;
   logic [19:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_done, irq_eof, irq_err;

   int compared = 0;
   int mismatched = 0;

   logic [31:0] mem [1024];
   int          exp_addr [$];
   logic [31:0] exp_data [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   dmarx_chain_dma #(.FIFO_DEPTH(8)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_done(irq_done), .irq_eof(irq_eof),
      .irq_err(irq_err)
   );

   // memory model: write at the edge, read data one cycle later
   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
         else        mem_rdata <= mem[mem_addr[11:2]];
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // per-clock comparison of memory writes against the reference sequence
   always @(negedge clk) begin
      if (rst_n && mem_we) begin
         if (exp_addr.size() == 0) begin
            chk("R2/R3 unexpected write addr", 32'(mem_addr), 32'hFFFFFFFF);
         end else begin
            chk("R3/R4 write addr", 32'(mem_addr), 32'(exp_addr[0]));
            chk("R3/R4 write data", mem_wdata, exp_data[0]);
            void'(exp_addr.pop_front());
            void'(exp_data.pop_front());
         end
      end
   end

   function automatic logic [31:0] dw0(bit own, bit ef, int len, int size);
      return {own, ef, 6'b0, len[11:0], size[11:0]};
   endfunction

   task automatic expect_wr(int a, logic [31:0] d);
      exp_addr.push_back(a);
      exp_data.push_back(d);
   endtask

   task automatic wr_reg(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_reg(logic [2:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic push_word(logic [31:0] v);
      @(negedge clk);
      in_valid = 1'b1; in_data = v;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1 in_valid = 1'b0;
   endtask

   task automatic put_desc(int a, logic [31:0] w0, int bufp, int nxt);
      mem[a >> 2]       = w0;
      mem[(a >> 2) + 1] = 32'(bufp);
      mem[(a >> 2) + 2] = 32'(nxt);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      logic [31:0] v;
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 irq_done", 32'(irq_done), 0);
      chk("R1 irq_eof", 32'(irq_eof), 0);
      chk("R1 irq_err", 32'(irq_err), 0);
      chk("R1 mem_req", 32'(mem_req), 0);
      chk("R1 in_ready", 32'(in_ready), 1);
      rst_n = 1'b1;

      // ---- two-descriptor chain, no frame count (R3 R4 R5 R6)
      put_desc(32'h100, dw0(1, 0, 0, 16), 32'h400, 32'h110);
      put_desc(32'h110, dw0(1, 1, 0, 8), 32'h500, 0);
      for (int k = 0; k < 4; k++) expect_wr(32'h400 + 4*k, 32'hA000 + k);
      expect_wr(32'h100, dw0(0, 0, 16, 16));
      for (int k = 0; k < 2; k++) expect_wr(32'h500 + 4*k, 32'hB000 + k);
      expect_wr(32'h110, dw0(0, 1, 8, 8));
      wr_reg(3'd3, 32'h7);
      wr_reg(3'd1, 32'h100);
      wr_reg(3'd2, 32'h0);
      for (int k = 0; k < 4; k++) push_word(32'hA000 + k);
      wr_reg(3'd0, 32'h1);
      for (int k = 0; k < 2; k++) push_word(32'hB000 + k);
      repeat (40) @(negedge clk);
      chk("R3 all writes seen", 32'(exp_addr.size()), 0);
      chk("R6 chain end leaves desc1 owner clear", mem[32'h110 >> 2], dw0(0, 1, 8, 8));
      chk("R5 irq_done", 32'(irq_done), 1);
      chk("R7 irq_eof off when count 0", 32'(irq_eof), 0);
      chk("R2 irq_err", 32'(irq_err), 0);

      // R8 clear
      wr_reg(3'd5, 32'h7);
      rd_reg(3'd4, v);
      chk("R8 raw cleared", v, 0);
      chk("R8 irq_done cleared", 32'(irq_done), 0);

      // ---- restart without giving descriptors back: owner error (R2)
      wr_reg(3'd0, 32'h1);
      repeat (10) @(negedge clk);
      chk("R2 irq_err", 32'(irq_err), 1);
      chk("R2 irq_done", 32'(irq_done), 0);
      chk("R2 desc untouched", mem[32'h100 >> 2], dw0(0, 0, 16, 16));
      wr_reg(3'd5, 32'h7);

      // ---- reuse by setting only owner, frame count of 5 words (R4 R7 R8)
      mem[32'h100 >> 2][31] = 1'b1;
      mem[32'h110 >> 2][31] = 1'b1;
      for (int k = 0; k < 4; k++) expect_wr(32'h400 + 4*k, 32'hC000 + k);
      expect_wr(32'h100, dw0(0, 0, 16, 16));
      expect_wr(32'h500, 32'hC004);
      expect_wr(32'h110, dw0(0, 1, 4, 8));
      wr_reg(3'd3, 32'h2);
      wr_reg(3'd2, 32'd5);
      wr_reg(3'd0, 32'h1);
      for (int k = 0; k < 5; k++) push_word(32'hC000 + k);
      repeat (30) @(negedge clk);
      chk("R7 all writes seen", 32'(exp_addr.size()), 0);
      chk("R7 partial length", mem[32'h110 >> 2], dw0(0, 1, 4, 8));
      chk("R7 irq_eof", 32'(irq_eof), 1);
      chk("R8 done masked", 32'(irq_done), 0);
      rd_reg(3'd4, v);
      chk("R8 raw done+eof", v, 32'h3);
      // R7 engine stopped: a further word stays unused
      push_word(32'hDEAD);
      repeat (10) @(negedge clk);
      chk("R7 no write after stop", 32'(exp_addr.size()), 0);
      wr_reg(3'd5, 32'h7);

      // ---- FIFO fill and soft reset (R9 R10)
      for (int k = 0; k < 7; k++) push_word(32'hE000 + k);
      @(negedge clk);
      chk("R9 in_ready low when full", 32'(in_ready), 0);
      wr_reg(3'd0, 32'h2);
      chk("R10 in_ready low in soft reset", 32'(in_ready), 0);
      wr_reg(3'd0, 32'h0);
      chk("R10 in_ready back", 32'(in_ready), 1);
      put_desc(32'h120, dw0(1, 0, 0, 4), 32'h600, 0);
      expect_wr(32'h600, 32'h00C0FFEE);
      expect_wr(32'h120, dw0(0, 0, 4, 4));
      wr_reg(3'd3, 32'h7);
      wr_reg(3'd2, 32'h0);
      wr_reg(3'd1, 32'h120);
      push_word(32'h00C0FFEE);
      wr_reg(3'd0, 32'h1);
      repeat (20) @(negedge clk);
      chk("R10 flushed, fresh word stored", 32'(exp_addr.size()), 0);
      chk("R5 single word done", 32'(irq_done), 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule